// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block sits between a single bus master and a byte-wide DRAM. It turns one-byte read and write requests into row-strobe, column-strobe and write-strobe timing on a multiplexed address bus. It remembers which row is still open. A new access can reuse that row as a short column-only cycle, but only when the requester allows it and the address stays in the same 256-byte page. Otherwise the block runs a full cycle: close the row, open it again, then strobe the column.

Page mode is never assumed. With each request the master supplies a hint that allows page mode and a marker that flags an opcode fetch. Opcode fetches always take the full cycle. A free-running timer also schedules refresh cycles in which the column strobe falls before the row strobe, so the DRAM keeps its own row counter. A refresh closes any open row, which means the access that follows it is always a full cycle.

Top module: `dramPageSeq`

## Requirements
- R1: After reset, dramRasN, dramCasN and dramWeN are high, respValid is low and reqReady is high.
- R2: A full-cycle access raises respValid for exactly one cycle, in the 5th clock cycle after the edge that accepted the request (5 ticks).
- R3: An access takes 4 ticks (respValid in the 4th cycle after acceptance) when all of the following hold: a row is open, pageHint is 1, reqSync is 0, and reqAddr[15:8] equals the open row.
- R4: An access whose pageHint is 0, or whose reqAddr[15:8] differs from the open row, takes the 5-tick full cycle.
- R5: A request with reqSync=1 (opcode fetch) always takes the 5-tick full cycle, whatever the hint and the page.
- R6: During the respValid cycle of a read, respRdata holds the DRAM byte at reqAddr.
- R7: A write drives reqWdata onto dramDqOut with dramWeN low while the column strobe is low, so a later read of the same address returns that byte. dramWeN is never low while dramRasN is high.
- R8: Every REF_INTERVAL clock cycles (default 128) the block issues a refresh. dramCasN falls while dramRasN is high, and dramRasN falls one cycle later. When the block is idle, consecutive refreshes are exactly REF_INTERVAL cycles apart.
- R9: After a refresh, the next access takes the 5-tick full cycle even if it would otherwise qualify for page mode.
- R10: dramAddr carries reqAddr[15:8] when the row strobe falls and reqAddr[7:0] when the column strobe falls.
- R11: reqReady is low while an access or a refresh is in progress. A request is accepted only on an edge where reqValid and reqReady are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock; one tick per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address; upper byte is the row |
| reqWdata | input | 8 | Write data |
| reqSync | input | 1 | Request is an opcode fetch |
| pageHint | input | 1 | Page mode allowed for this request |
| respValid | output | 1 | Final tick of an access |
| respRdata | output | 8 | Read data, valid with respValid |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramAddr | output | 8 | Multiplexed row/column address |
| dramDqOut | output | 8 | Data driven to the DRAM |
| dramDqOe | output | 1 | Data output enable |
| dramDqIn | input | 8 | Data from the DRAM |

## Verification
The embedded assertions check the following on every cycle:
- the response lasts one cycle;
- opcode fetches and unhinted requests enter the full cycle;
- a column-only cycle starts only on the open row;
- the write strobe appears only under an active row strobe;
- a waiting refresh request is never dropped;
- a refresh leaves the row closed.

Only the bench scenarios can show the rest: the exact 4-versus-5-tick latencies, the row/column address muxing and the data path (proven by reads that return the right bytes and by readback of writes), the exact refresh spacing, and the forced full cycle after a refresh.

// File: rtl/dpsPkg.sv
package dpsPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_R_PRE, ST_R_ROW, ST_R_COL, ST_R_HOLD, ST_R_DONE,
    ST_P_PRE, ST_P_COL, ST_P_HOLD, ST_P_DONE,
    ST_F_PRE, ST_F_CAS, ST_F_RAS, ST_F_HOLD, ST_F_END
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture request fields
    logic openRow;    // record the row now strobed
    logic closeRow;   // forget the open row
    logic selCol;     // drive column half of address
    logic capture;    // capture read data
    logic pageStart;  // first tick of a column-only cycle
  } dpStrobe_t;

endpackage

// File: rtl/dpsRefreshTimer.sv
module dpsRefreshTimer #(
  parameter int INTERVAL = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic refAck,
  output logic refPending
);
  localparam int CNT_W = $clog2(INTERVAL);

  logic [CNT_W-1:0] tickCnt;
  logic             wrapNow;

  assign wrapNow = (tickCnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt    <= '0;
      refPending <= 1'b0;
    end else begin
      tickCnt <= wrapNow ? '0 : tickCnt + 1'b1;
      if (wrapNow)     refPending <= 1'b1;
      else if (refAck) refPending <= 1'b0;
    end
  end

  // R8: a waiting refresh survives until the control acknowledges it
  a_r8_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && !refAck) |=> refPending);

endmodule

// File: rtl/dpsDatapath.sv
module dpsDatapath
  import dpsPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] dramDqIn,
  output logic              pageMatch,
  output logic              rowOpen,
  output logic              isWrite,
  output logic [((ADDR_W-COL_W) > COL_W ? (ADDR_W-COL_W) : COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic [DATA_W-1:0] respRdata
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [ROW_W-1:0]  openRowQ;
  logic              rowOpenQ;
  logic              writeQ;
  logic [MUX_W-1:0]  rowMux;
  logic [MUX_W-1:0]  colMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      writeQ   <= 1'b0;
      rdataQ   <= '0;
      openRowQ <= '0;
      rowOpenQ <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
      end
      if (strobe.closeRow) rowOpenQ <= 1'b0;
      else if (strobe.openRow) begin
        rowOpenQ <= 1'b1;
        openRowQ <= addrQ[ADDR_W-1:COL_W];
      end
      if (strobe.capture) rdataQ <= dramDqIn;
    end
  end

  generate
    if (ROW_W == MUX_W) begin : g_rowFull
      assign rowMux = addrQ[ADDR_W-1:COL_W];
    end else begin : g_rowPad
      assign rowMux = {{(MUX_W-ROW_W){1'b0}}, addrQ[ADDR_W-1:COL_W]};
    end
    if (COL_W == MUX_W) begin : g_colFull
      assign colMux = addrQ[COL_W-1:0];
    end else begin : g_colPad
      assign colMux = {{(MUX_W-COL_W){1'b0}}, addrQ[COL_W-1:0]};
    end
  endgenerate

  assign pageMatch = rowOpenQ && (reqAddr[ADDR_W-1:COL_W] == openRowQ);
  assign rowOpen   = rowOpenQ;
  assign isWrite   = writeQ;
  assign dramAddr  = strobe.selCol ? colMux : rowMux;
  assign dramDqOut = wdataQ;
  assign respRdata = rdataQ;

  // R3: a column-only cycle may only begin on the row still held open
  a_r3_page_on_open_row: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pageStart |-> (rowOpenQ && addrQ[ADDR_W-1:COL_W] == openRowQ));

endmodule

// File: rtl/dpsControl.sv
module dpsControl
  import dpsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqSync,
  input  logic      pageHint,
  input  logic      pageMatch,
  input  logic      rowOpen,
  input  logic      isWrite,
  input  logic      refPending,
  output logic      reqReady,
  output logic      respValid,
  output logic      refAck,
  output dpStrobe_t strobe,
  output logic      dramRasN,
  output logic      dramCasN,
  output logic      dramWeN,
  output logic      dramDqOe
);
  seqState_e state, stateN;
  logic accept, goPage, inAccess, colLow;

  assign reqReady = (state == ST_IDLE) && !refPending;
  assign accept   = reqReady && reqValid;
  assign goPage   = pageHint && !reqSync && pageMatch;
  assign refAck   = (state == ST_IDLE) && refPending;

  always_comb begin
    stateN = state;
    case (state)
      ST_IDLE: begin
        if (refPending)    stateN = ST_F_PRE;
        else if (reqValid) stateN = goPage ? ST_P_PRE : ST_R_PRE;
      end
      ST_R_PRE:  stateN = ST_R_ROW;
      ST_R_ROW:  stateN = ST_R_COL;
      ST_R_COL:  stateN = ST_R_HOLD;
      ST_R_HOLD: stateN = ST_R_DONE;
      ST_R_DONE: stateN = ST_IDLE;
      ST_P_PRE:  stateN = ST_P_COL;
      ST_P_COL:  stateN = ST_P_HOLD;
      ST_P_HOLD: stateN = ST_P_DONE;
      ST_P_DONE: stateN = ST_IDLE;
      ST_F_PRE:  stateN = ST_F_CAS;
      ST_F_CAS:  stateN = ST_F_RAS;
      ST_F_RAS:  stateN = ST_F_HOLD;
      ST_F_HOLD: stateN = ST_F_END;
      ST_F_END:  stateN = ST_IDLE;
      default:   stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateN;
  end

  always_comb begin
    inAccess = (state inside {ST_R_PRE, ST_R_ROW, ST_R_COL, ST_R_HOLD, ST_R_DONE,
                              ST_P_PRE, ST_P_COL, ST_P_HOLD, ST_P_DONE});
    colLow   = (state inside {ST_R_COL, ST_R_HOLD, ST_R_DONE,
                              ST_P_COL, ST_P_HOLD, ST_P_DONE});

    strobe.latchReq  = accept;
    strobe.openRow   = (state == ST_R_ROW);
    strobe.closeRow  = (state == ST_R_PRE) || (state == ST_F_PRE);
    strobe.selCol    = colLow || (state == ST_P_PRE);
    strobe.capture   = (state == ST_R_HOLD) || (state == ST_P_HOLD);
    strobe.pageStart = (state == ST_P_PRE);

    dramRasN = !((state inside {ST_R_ROW, ST_R_COL, ST_R_HOLD, ST_R_DONE,
                                ST_P_PRE, ST_P_COL, ST_P_HOLD, ST_P_DONE,
                                ST_F_RAS, ST_F_HOLD})
                 || ((state == ST_IDLE) && rowOpen));
    dramCasN = !(colLow || (state inside {ST_F_CAS, ST_F_RAS, ST_F_HOLD}));
    dramWeN  = !(colLow && isWrite);
    dramDqOe = inAccess && isWrite;
    respValid = (state == ST_R_DONE) || (state == ST_P_DONE);
  end

  // R2: the response strobe lasts one cycle
  a_r2_resp_single: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
  // R5: opcode fetches always enter the full cycle
  a_r5_sync_full: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqSync) |=> (state == ST_R_PRE));
  // R4: without the hint the full cycle is used
  a_r4_nohint_full: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !pageHint) |=> (state == ST_R_PRE));
  // R9: a finished refresh leaves no row open
  a_r9_refresh_closes: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_F_END) |=> !rowOpen);

endmodule

// File: rtl/dramPageSeq.sv
module dramPageSeq
  import dpsPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int COL_W        = 8,
  parameter int REF_INTERVAL = 128,
  localparam int MUX_W = ((ADDR_W-COL_W) > COL_W) ? (ADDR_W-COL_W) : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqSync,
  input  logic              pageHint,
  output logic              respValid,
  output logic [DATA_W-1:0] respRdata,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic [MUX_W-1:0]  dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);
  dpStrobe_t strobe;
  logic pageMatch, rowOpen, isWrite, refPending, refAck;

  dpsRefreshTimer #(.INTERVAL(REF_INTERVAL)) i_timer (
    .clk(clk), .rstN(rstN), .refAck(refAck), .refPending(refPending)
  );

  dpsControl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSync(reqSync),
    .pageHint(pageHint), .pageMatch(pageMatch), .rowOpen(rowOpen),
    .isWrite(isWrite), .refPending(refPending), .reqReady(reqReady),
    .respValid(respValid), .refAck(refAck), .strobe(strobe),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramDqOe(dramDqOe)
  );

  dpsDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .dramDqIn(dramDqIn),
    .pageMatch(pageMatch), .rowOpen(rowOpen), .isWrite(isWrite),
    .dramAddr(dramAddr), .dramDqOut(dramDqOut), .respRdata(respRdata)
  );

  // R7: the write strobe only appears under an active row strobe
  a_r7_we_under_ras: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> !dramRasN);

endmodule

// File: tb/test_dramPageSeq.sv
`timescale 1ns/1ps
module test_dramPageSeq;
  localparam int REF_INT = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSync = 1'b0, pageHint = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, respValid, dramRasN, dramCasN, dramWeN, dramDqOe;
  logic [7:0] respRdata, dramAddr, dramDqOut;
  logic [7:0] dramDqIn = '0;

  always #10 clk = ~clk;

  dramPageSeq #(.REF_INTERVAL(REF_INT)) i_dramPageSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSync(reqSync), .pageHint(pageHint), .respValid(respValid),
    .respRdata(respRdata), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // ---- DRAM model, observed at the ports ----
  logic [7:0] memA [int];
  logic [7:0] mRow = '0, mCol = '0;
  logic prevRas = 1'b1, prevCas = 1'b1;
  int refCount = 0, lastRefCyc = 0, lastGap = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevRas = 1'b1; prevCas = 1'b1;
    end else begin
      if (prevRas && !dramRasN) begin
        if (!dramCasN) begin
          refCount++;
          lastGap = cyc - lastRefCyc;
          lastRefCyc = cyc;
        end else mRow = dramAddr;
      end
      if (prevCas && !dramCasN && !dramRasN) begin
        mCol = dramAddr;
        if (!dramWeN) memA[int'({mRow, mCol})] = dramDqOut;
      end
      if (prevCas && !dramCasN && dramRasN)
        check(reqReady == 1'b0, "R11", "ready during refresh", reqReady, 0);
      if (!dramCasN && !dramRasN && dramWeN)
        dramDqIn = memA.exists(int'({mRow, mCol})) ? memA[int'({mRow, mCol})]
                                                   : pattern({mRow, mCol});
      prevRas = dramRasN; prevCas = dramCasN;
    end
  end

  // ---- scoreboard ----
  typedef struct {
    int         cycle;
    bit         isRead;
    logic [7:0] data;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];
  logic [7:0] shadow [int];
  logic [7:0] rowModel = '0;
  bit rowValid = 0;
  int lastRef = 0;

  task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] wd,
                        input bit hint, input bit sync);
    expItem_t it;
    bit page;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqWdata = wd;
    pageHint = hint; reqSync = sync;
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    if (refCount != lastRef) begin
      rowValid = 0; lastRef = refCount;
      it.tag = "R9";
    end else if (sync) it.tag = "R5";
    else if (!hint || !rowValid || rowModel != a[15:8]) it.tag = "R4";
    else it.tag = "R3";
    page = rowValid && hint && !sync && (rowModel == a[15:8]);
    if (page) it.tag = "R3";
    else if (it.tag == "R3") it.tag = "R2";
    rowModel = a[15:8]; rowValid = 1;
    it.cycle  = cyc + (page ? 3 : 4);
    it.isRead = !wr;
    it.data   = shadow.exists(int'(a)) ? shadow[int'(a)] : pattern(a);
    if (wr) shadow[int'(a)] = wd;
    expQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R11", "ready while busy", reqReady, 0);
  endtask

  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) check(0, "R2", "unexpected response", 1, 0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check(cyc == e.cycle, e.tag, "response cycle", cyc, e.cycle);
        if (e.isRead)
          check(respRdata == e.data, "R6", "read data", respRdata, e.data);
      end
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- stimulus ----
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dramRasN == 1'b1, "R1", "ras", dramRasN, 1);
    check(dramCasN == 1'b1, "R1", "cas", dramCasN, 1);
    check(dramWeN == 1'b1,  "R1", "we", dramWeN, 1);
    check(respValid == 1'b0,"R1", "resp", respValid, 0);
    check(reqReady == 1'b1, "R1", "ready", reqReady, 1);

    // R8 idle refresh spacing
    wait (refCount == 3);
    check(lastGap == REF_INT, "R8", "refresh gap", lastGap, REF_INT);

    access(16'h1234, 0, 8'h00, 1, 0);   // full cycle after refresh
    access(16'h1256, 0, 8'h00, 1, 0);   // R3 same page
    access(16'h1280, 1, 8'hA5, 1, 0);   // R7 page write
    access(16'h1280, 0, 8'h00, 0, 0);   // R4 no hint, reads A5
    access(16'h12FF, 0, 8'h00, 1, 1);   // R5 opcode fetch
    access(16'h1300, 0, 8'h00, 1, 0);   // R4 page change
    access(16'h1301, 1, 8'h3C, 1, 0);   // page write
    access(16'h1301, 0, 8'h00, 1, 0);   // R10 readback
    wait (refCount == lastRef + 1);
    repeat (8) @(negedge clk);
    access(16'h1302, 0, 8'h00, 1, 0);   // R9 forced full cycle

    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      a = {8'h40 + 8'(i % 3), 8'(i * 37)};
      access(a, (i % 4) == 1, 8'(i * 11 + 7), (i % 5) != 0, (i % 7) == 3);
    end
    for (int i = 0; i < 20; i++)
      access({8'h40 + 8'(i % 3), 8'(i * 37 + 37)}, 0, 8'h00, 1, 0);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2", "responses outstanding", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule